// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block measures how fast a fan turns by timing the gap between pulses on its tachometer line. A 16-bit counter is loaded by software, usually to all-ones, and is then started. It counts down once per prescaled clock tick, where the tick rate is the peripheral clock divided by one plus an 8-bit prescaler value. The tachometer input passes through a two-flop synchronizer, and a software-chosen edge (rising or falling) is detected on it. When that edge arrives, the running count is copied into a capture register, a capture-pending flag is raised and counting halts.

If no edge arrives before the counter falls to a programmed limit, a timeout-pending flag is raised instead and counting halts with the counter at the limit. Software computes the interval from the difference between the start value and the captured count. Because the fan gives two pulses per revolution, the speed in RPM is clk × 60 / ((prescaler+1) × interval × 2). Six pending flags, a matching enable mask and a write-one-to-clear port drive one level-sensitive interrupt line.

Top module: `tach_timer`

## Requirements
- R1: After reset, the counter (address 0) and capture (address 1) registers read 0xFFFF, the limit (address 2), prescaler (address 3), control (address 4), pending (address 5) and enable (address 7) registers read 0, and irq is low.
- R2: The counter, capture and limit registers hold 16 bits written at their addresses. The prescaler keeps only the low 8 bits. The enable register keeps only the low 6 bits. Address 6 (clear port) always reads 0.
- R3: While control bit 0 (run) is 1, the counter decrements by one once every prescaler+1 clocks. The first decrement lands on the (prescaler+1)-th rising edge after the edge that wrote run=1.
- R4: The tach input is sampled by two flops. Control bit 1 selects the active edge: 0 for rising, 1 for falling. A transition is acted on at the third rising clock edge after it, and the captured value is the count held just before that edge.
- R5: On an active edge while running, the count is copied into the capture register, pending bit 0 is set, run clears to 0 and the counter holds its value.
- R6: While running, when the counter equals the limit and no capture occurs in that cycle, pending bit 4 is set and run clears to 0. The counter then stays at the limit. A capture in the same cycle takes priority.
- R7: While run is 0, tach edges set no pending bit and the counter holds its value.
- R8: Writing a mask to address 6 clears the pending bits that are 1 in the mask and leaves the other pending bits unchanged.
- R9: irq is high exactly when some pending bit and its enable bit are both 1.
- R10: Writing 0 to control bit 0 stops counting. The counter keeps the value it reached at the edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_in | input | 1 | Asynchronous tachometer input |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Level interrupt request |

## Verification
Captures are swept over several prescaler values and several tach delays after start. A mistake in the tick spacing and a mistake in the synchronizer latency therefore give different captured counts. Timeouts are checked on both sides of the exact cycle of the limit match, at two prescaler values. This separates an off-by-one in the compare from a late flag. Falling-edge selection, edges seen while stopped, a stop written by software, and partial clears with the interrupt enable masking are each tried on their own, so that a fault in one path is not hidden by another.

// File: rtl/tach_pkg.sv
package tach_pkg;
    localparam int CNT_W   = 16;
    localparam int PSC_W   = 8;
    localparam int ST_W    = 6;
    localparam int ADDR_W  = 3;
    localparam int ST_CAP  = 0;
    localparam int ST_TMO  = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_COUNT = 3'd0,
        A_CAPT  = 3'd1,
        A_LIMIT = 3'd2,
        A_PSC   = 3'd3,
        A_CTRL  = 3'd4,
        A_PEND  = 3'd5,
        A_CLEAR = 3'd6,
        A_MASK  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic fall_sel;
        logic run;
    } ctrl_t;

    function automatic logic [ST_W-1:0] event_bits(input logic cap, input logic tmo);
        logic [ST_W-1:0] v;
        v = '0;
        v[ST_CAP] = cap;
        v[ST_TMO] = tmo;
        return v;
    endfunction
endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tach_in,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], tach_in};
    end

    logic now_v, prev_v;
    assign now_v  = chain[STAGES-1];
    assign prev_v = chain[STAGES];
    assign edge_pulse = fall_sel ? (prev_v & ~now_v) : (now_v & ~prev_v);

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (edge_pulse && $stable(fall_sel)) |=> !edge_pulse); // R4
endmodule

// File: rtl/tach_presc.sv
module tach_presc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run)        phase <= '0;
        else if (phase == limit) phase <= '0;
        else                     phase <= phase + 1'b1;
    end

    assign tick = run && (phase == limit);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && limit != '0) |=> (!tick || limit == '0)); // R3
endmodule

// File: rtl/tach_count.sv
module tach_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         edge_pulse,
    input  logic [W-1:0] limit,
    input  logic         cnt_we,
    input  logic         cap_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         cap_evt,
    output logic         tmo_evt
);
    assign cap_evt = run && edge_pulse;
    assign tmo_evt = run && !edge_pulse && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst)                                   cnt <= '1;
        else if (cnt_we)                           cnt <= wdata;
        else if (tick && !cap_evt && !tmo_evt)     cnt <= cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          cap <= '1;
        else if (cap_evt) cap <= cnt;
        else if (cap_we)  cap <= wdata;
    end

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !cap_evt && !tmo_evt && !cnt_we) |=> cnt == $past(cnt) - 1'b1); // R3
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_we) |=> $stable(cnt)); // R7
    AST_CAP_COPY: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> cap == $past(cnt)); // R5
endmodule

// File: rtl/tach_timer.sv
module tach_timer
    import tach_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tach_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] limit;
    logic [ST_W-1:0]  pend, mask;
    logic [CNT_W-1:0] cnt, cap;
    logic             edge_pulse, tick, cap_evt, tmo_evt;
    logic             wr_ctrl, wr_clear;

    assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
    assign wr_clear = reg_we && (reg_addr == A_CLEAR);

    tach_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .tach_in(tach_in),
        .fall_sel(ctrl.fall_sel), .edge_pulse(edge_pulse)
    );

    tach_presc #(.W(PSC_W)) u_presc (
        .clk(clk), .rst(rst), .run(ctrl.run), .limit(psc), .tick(tick)
    );

    tach_count #(.W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .run(ctrl.run), .tick(tick),
        .edge_pulse(edge_pulse), .limit(limit),
        .cnt_we(reg_we && reg_addr == A_COUNT),
        .cap_we(reg_we && reg_addr == A_CAPT),
        .wdata(reg_wdata), .cnt(cnt), .cap(cap),
        .cap_evt(cap_evt), .tmo_evt(tmo_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            psc   <= '0;
            limit <= '0;
            mask  <= '0;
        end else begin
            if (wr_ctrl)                     ctrl <= ctrl_t'(reg_wdata[1:0]);
            else if (cap_evt || tmo_evt)     ctrl.run <= 1'b0;
            if (reg_we && reg_addr == A_PSC)   psc   <= reg_wdata[PSC_W-1:0];
            if (reg_we && reg_addr == A_LIMIT) limit <= reg_wdata;
            if (reg_we && reg_addr == A_MASK)  mask  <= reg_wdata[ST_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~(wr_clear ? reg_wdata[ST_W-1:0] : '0))
                         | event_bits(cap_evt, tmo_evt);
    end

    assign irq = |(pend & mask);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_COUNT: reg_rdata = cnt;
            A_CAPT:  reg_rdata = cap;
            A_LIMIT: reg_rdata = limit;
            A_PSC:   reg_rdata[PSC_W-1:0] = psc;
            A_CTRL:  reg_rdata[1:0] = ctrl;
            A_PEND:  reg_rdata[ST_W-1:0] = pend;
            A_MASK:  reg_rdata[ST_W-1:0] = mask;
            default: reg_rdata = '0;
        endcase
    end

    AST_STOP_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        ((cap_evt || tmo_evt) && !wr_ctrl) |=> !ctrl.run); // R5
    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> pend[ST_CAP]); // R5
    AST_TMO_FLAG: assert property (@(posedge clk) disable iff (rst)
        tmo_evt |=> pend[ST_TMO]); // R6
    AST_NO_TMO_ON_CAP: assert property (@(posedge clk) disable iff (rst)
        cap_evt |-> !tmo_evt); // R6
endmodule

// File: tb/tach_timer_bench.sv
module tach_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tach_in = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tach_timer u_tach_timer (
        .clk(clk), .rst(rst), .tach_in(tach_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rchk(input string req, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rchk("R1", 3'd0, 16'hFFFF);
        rchk("R1", 3'd1, 16'hFFFF);
        rchk("R1", 3'd2, 16'h0000);
        rchk("R1", 3'd3, 16'h0000);
        rchk("R1", 3'd4, 16'h0000);
        rchk("R1", 3'd5, 16'h0000);
        rchk("R1", 3'd7, 16'h0000);
        chk("R1", {15'd0, irq}, 16'd0);

        // R2 register widths
        wr(3'd2, 16'h1234); rchk("R2", 3'd2, 16'h1234);
        wr(3'd3, 16'h01AB); rchk("R2", 3'd3, 16'h00AB);
        wr(3'd7, 16'hFFFF); rchk("R2", 3'd7, 16'h003F);
        rchk("R2", 3'd6, 16'h0000);
        wr(3'd1, 16'hBEEF); rchk("R2", 3'd1, 16'hBEEF);
        wr(3'd7, 16'h0000);
        wr(3'd2, 16'h0000);

        // R7 edges ignored while stopped
        wr(3'd0, 16'hFFFF);
        #1 tach_in = 1'b1;
        repeat (6) @(posedge clk);
        #1 rchk("R7", 3'd5, 16'h0000);
        rchk("R7", 3'd0, 16'hFFFF);
        tach_in = 1'b0;
        repeat (6) @(posedge clk);
        #1 rchk("R7", 3'd5, 16'h0000);

        // R3 R4 R5 rising-edge capture sweep
        for (int p = 0; p < 4; p++) begin
            if (p == 2) continue;
            for (int di = 0; di < 3; di++) begin
                int dly;
                logic [15:0] expv;
                dly  = (di == 0) ? 0 : (di == 1) ? 2 : 7;
                expv = 16'hFFFF - 16'((dly + 2) / (p + 1));
                wr(3'd3, 16'(p));
                wr(3'd0, 16'hFFFF);
                wr(3'd6, 16'h003F);
                wr(3'd4, 16'h0001);
                repeat (dly) @(posedge clk);
                #1 tach_in = 1'b1;
                repeat (6) @(posedge clk);
                #1;
                rchk("R4", 3'd1, expv);
                rchk("R5", 3'd5, 16'h0001);
                rchk("R5", 3'd4, 16'h0000);
                rchk("R3", 3'd0, expv);
                tach_in = 1'b0;
                repeat (5) @(posedge clk);
            end
        end

        // R4 falling edge select
        #1 tach_in = 1'b1;
        repeat (5) @(posedge clk);
        wr(3'd3, 16'd1);
        wr(3'd0, 16'hFFFF);
        wr(3'd6, 16'h003F);
        wr(3'd4, 16'h0003);
        repeat (4) @(posedge clk);
        #1 tach_in = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        rchk("R4", 3'd1, 16'hFFFF - 16'd3);
        rchk("R4", 3'd5, 16'h0001);
        rchk("R4", 3'd4, 16'h0002);

        // R9 interrupt masking, R8 partial clear
        chk("R9", {15'd0, irq}, 16'd0);
        wr(3'd7, 16'h0010); #1 chk("R9", {15'd0, irq}, 16'd0);
        wr(3'd7, 16'h0001); #1 chk("R9", {15'd0, irq}, 16'd1);
        wr(3'd6, 16'h0010); rchk("R8", 3'd5, 16'h0001);
        chk("R9", {15'd0, irq}, 16'd1);
        wr(3'd6, 16'h0001); rchk("R8", 3'd5, 16'h0000);
        chk("R9", {15'd0, irq}, 16'd0);
        wr(3'd4, 16'h0000);
        wr(3'd7, 16'h0000);

        // R6 timeout at exact cycle
        for (int p = 0; p < 3; p += 2) begin
            wr(3'd3, 16'(p));
            wr(3'd2, 16'hFFFF - 16'd12);
            wr(3'd0, 16'hFFFF);
            wr(3'd6, 16'h003F);
            wr(3'd4, 16'h0001);
            repeat ((p + 1) * 12 - 1) @(posedge clk);
            @(posedge clk);
            #1 rchk("R6", 3'd5, 16'h0000);
            rchk("R6", 3'd0, 16'hFFFF - 16'd12);
            @(posedge clk);
            #1 rchk("R6", 3'd5, 16'h0010);
            rchk("R6", 3'd4, 16'h0000);
            repeat (4) @(posedge clk);
            #1 rchk("R6", 3'd0, 16'hFFFF - 16'd12);
            wr(3'd7, 16'h0010); #1 chk("R9", {15'd0, irq}, 16'd1);
            wr(3'd7, 16'h0000);
        end
        wr(3'd2, 16'h0000);

        // R10 software stop
        wr(3'd3, 16'd1);
        wr(3'd0, 16'hFFFF);
        wr(3'd6, 16'h003F);
        wr(3'd4, 16'h0001);
        repeat (9) @(posedge clk);
        wr(3'd4, 16'h0000);
        repeat (6) @(posedge clk);
        #1 rchk("R10", 3'd0, 16'hFFFF - 16'd5);
        rchk("R10", 3'd5, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule